// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital half of a supply-voltage supervisor. It takes two comparator outputs that already have hysteresis. One says the supply is below the reset threshold. The other says the supply is below a higher early-warning threshold. From these the block drives an active-low system reset that other devices on the board can share. It also gives software a real-time warning status bit and a maskable warning interrupt.

While the enabled low-voltage input is active, the reset output is low. After the condition clears, reset is stretched for 256 or 4096 clock cycles, chosen by a static configuration pin. The chip reset input starts the same stretch. Two static configuration pins stand in for factory option settings.

Software reaches the block through one 8-bit register with a write strobe and a combinational read. The warning comparator is brought into the clock domain by a synchronizer. The interrupt fires on each change of the warning level in either direction. It is silenced for any change that happens while the reset output is active, so a supply that recovers inside the stretch window raises no interrupt.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: With `cfg_lvr_en`=1, a high `lv_below_i` sampled on a clock edge drives `sys_rst_n_o` low from that edge on.
- R2: With `cfg_lvr_en`=0, `lv_below_i` has no effect: once `sys_rst_n_o` is high it stays high.
- R3: Once `lv_below_i` (enabled) or `rst_n` is released, `sys_rst_n_o` stays low for exactly 256 further clock edges when `cfg_long_dly`=0, or 4096 when `cfg_long_dly`=1, and then goes high.
- R4: Register bit 0 (warning status, 1 = supply below the warning threshold) follows `warn_cmp_i` through a two-flop synchronizer, so it is valid two edges after the input changes. Writes to bit 0 are ignored.
- R5: With `cfg_lvr_en`=0, bit 0 reads 0 and no interrupt is raised, whatever `warn_cmp_i` does.
- R6: When bit 1 (interrupt enable, read/write) is 1, each change of the status bit in either direction sets bit 2 (pending, read-only) and `warn_irq_o` one edge after the status changes. When bit 1 is 0, changes are not latched.
- R7: A status change that occurs while `sys_rst_n_o` is low raises no interrupt. This includes a recovery during the stretch window. Leaving reset also creates no interrupt.
- R8: The pending flag stays set until a write with bit 3 = 1. Bit 3 always reads 0.
- R9: If a status change sets the pending flag on the same edge as a clearing write, the flag ends up set.
- R10: If the enabled `lv_below_i` reasserts during the stretch, the count restarts, and a full 256 or 4096 edges follow its next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| cfg_lvr_en | input | 1 | Static enable for the low-voltage reset and the warning function |
| cfg_long_dly | input | 1 | Static stretch select: 0 = 256 cycles, 1 = 4096 cycles |
| lv_below_i | input | 1 | Low-voltage comparator, 1 = supply below reset threshold |
| warn_cmp_i | input | 1 | Warning comparator (asynchronous), 1 = supply below warning threshold |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: bit0 status, bit1 enable, bit2 pending |
| sys_rst_n_o | output | 1 | Active-low system reset output |
| warn_irq_o | output | 1 | Warning interrupt request (level of pending flag) |

## Verification
The hardest case to reach from the ports is a warning change while the stretch counter is running and the reset output is still low. The interrupt that must not appear would only show once reset is released, hundreds of cycles later. The bench pulses the low-voltage input and moves the warning comparator back to "above" partway through the stretch. It then waits for the release and checks that the pending flag is still clear. The set-wins-over-clear case needs the clearing write to land on the exact edge where the synchronized change arrives. The bench times this by counting the synchronizer stages from the moment it drives the comparator.

// File: rtl/supmon_pkg.sv
// Package: shared constants for the supply monitor reset controller.
// Assumes: one 8-bit software register; bit positions are fixed here.
package supmon_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_WARN = 0;   // read-only live warning status
    localparam int BIT_IE   = 1;   // interrupt enable, read/write
    localparam int BIT_PEND = 2;   // pending flag, read-only
    localparam int BIT_CLR  = 3;   // write 1 to clear pending, reads 0

    // Reset stretcher states
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,   // low-voltage condition or chip reset active
        ST_STRETCH = 2'd1,   // condition gone, counting the delay
        ST_RUN     = 2'd2    // reset released
    } stretch_state_e;
endpackage

// File: rtl/supmon_sync.sv
// Module: supmon_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes: the input is a slow level (comparator output with hysteresis).
module supmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES < 2) begin : g_single
            logic one_q;
            // Single-flop variant for a caller that already synchronizes
            always_ff @(posedge clk) begin
                if (!rst_n) one_q <= 1'b0;
                else        one_q <= d_i;
            end
            assign q_o = one_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the input through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/supmon_stretch.sv
// Module: supmon_stretch
// Holds reset while the low-voltage condition is active, then for a
// selectable number of cycles afterwards. Reasserting the condition during
// the stretch restarts the count.
// Assumes: cfg_long_i is static; SHORT_DLY and LONG_DLY are at least 2.
module supmon_stretch
    import supmon_pkg::*;
#(
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_cond_i,
    input  logic cfg_long_i,
    output logic hold_o
);
    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY);

    stretch_state_e state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Pick the final count of the selected delay
    always_comb begin
        last_cnt = cfg_long_i ? CNT_W'(LONG_DLY - 1) : CNT_W'(SHORT_DLY - 1);
    end

    // State and counter: hold, count the stretch, then release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    if (!lv_cond_i) begin
                        state_q <= ST_STRETCH;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                ST_STRETCH: begin
                    if (lv_cond_i) begin
                        state_q <= ST_HOLD;
                        cnt_q   <= '0;
                    end else if (cnt_q == last_cnt) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q   <= cnt_q + CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    if (lv_cond_i) begin
                        state_q <= ST_HOLD;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    state_q <= ST_HOLD;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign hold_o = (state_q != ST_RUN);
endmodule

// File: rtl/supmon_warn_edge.sv
// Module: supmon_warn_edge
// Synchronizes the warning comparator, gates it with the enable and reports
// each change of the resulting status while reset is not held.
// Assumes: hold_i is the registered reset-active indication.
module supmon_warn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic warn_raw_i,
    input  logic hold_i,
    output logic warn_sts_o,
    output logic toggle_o
);
    logic warn_sync;
    logic prev_q;

    supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (warn_raw_i),
        .q_o   (warn_sync)
    );

    // Status is forced to 0 while the function is disabled
    always_comb begin
        warn_sts_o = enable_i & warn_sync;
    end

    // Previous status; keeps reloading during reset so no stale edge remains
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= warn_sts_o;
    end

    // A change counts only outside reset and with the function enabled
    always_comb begin
        toggle_o = enable_i & ~hold_i & (warn_sts_o ^ prev_q);
    end
endmodule

// File: rtl/supmon_irq_regs.sv
// Module: supmon_irq_regs
// Software register: live status, interrupt enable, sticky pending flag
// with write-1-to-clear; a set on the same edge as a clear wins.
// Assumes: a single register, so no address decoding.
module supmon_irq_regs
    import supmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             toggle_i,
    input  logic             warn_sts_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o
);
    logic ie_q;
    logic pend_q;
    logic unused_wbits;

    // Interrupt enable bit, written by software
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (wr_en_i) ie_q <= wdata_i[BIT_IE];
    end

    // Pending flag: set by an enabled change, cleared by write-1, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                           pend_q <= 1'b0;
        else if (toggle_i && ie_q)            pend_q <= 1'b1;
        else if (wr_en_i && wdata_i[BIT_CLR]) pend_q <= 1'b0;
    end

    // Read view of the register
    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_WARN] = warn_sts_i;
        rdata_o[BIT_IE]   = ie_q;
        rdata_o[BIT_PEND] = pend_q;
    end

    assign irq_o        = pend_q;
    assign unused_wbits = ^{wdata_i[BIT_WARN], wdata_i[BIT_PEND], wdata_i[REG_W-1:BIT_CLR+1]};
endmodule

// File: rtl/supmon_rst_ctrl.sv
// Module: supmon_rst_ctrl (top)
// Supply monitor reset controller: stretched active-low reset from the
// low-voltage comparator, plus warning status and interrupt.
// Assumes: comparator inputs carry hysteresis; configuration pins are static.
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int SHORT_DLY   = 256,
    parameter int LONG_DLY    = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_lvr_en,
    input  logic             cfg_long_dly,
    input  logic             lv_below_i,
    input  logic             warn_cmp_i,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sys_rst_n_o,
    output logic             warn_irq_o
);
    logic lv_cond;
    logic stretch_hold;
    logic warn_sts;
    logic warn_toggle;

    // The low-voltage input only matters when the option is enabled
    always_comb begin
        lv_cond = cfg_lvr_en & lv_below_i;
    end

    supmon_stretch #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lv_cond_i  (lv_cond),
        .cfg_long_i (cfg_long_dly),
        .hold_o     (stretch_hold)
    );

    supmon_warn_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (cfg_lvr_en),
        .warn_raw_i (warn_cmp_i),
        .hold_i     (stretch_hold),
        .warn_sts_o (warn_sts),
        .toggle_o   (warn_toggle)
    );

    supmon_irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .toggle_i   (warn_toggle),
        .warn_sts_i (warn_sts),
        .wr_en_i    (reg_wr_en),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .irq_o      (warn_irq_o)
    );

    assign sys_rst_n_o = ~stretch_hold;
endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
// Module: supmon_rst_ctrl_chk
// Property checker for supmon_rst_ctrl, attached by bind below.
// Assumes: configuration pins are held static between chip resets.
module supmon_rst_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_lvr_en,
    input logic       lv_below_i,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sys_rst_n_o,
    input logic       warn_irq_o,
    input logic       toggle
);
    AST_LV_DRIVES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lvr_en && lv_below_i) |=> !sys_rst_n_o); // R1

    AST_LV_IGNORED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lvr_en && sys_rst_n_o) |=> sys_rst_n_o); // R2

    AST_RELEASE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> !$past(cfg_lvr_en && lv_below_i)); // R3

    AST_STATUS_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_lvr_en |-> (reg_rdata[0] == 1'b0)); // R5

    AST_NO_IRQ_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_irq_o) |-> $past(sys_rst_n_o)); // R7

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_irq_o && !(reg_wr_en && reg_wdata[3])) |=> warn_irq_o); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && reg_rdata[1] && reg_wr_en && reg_wdata[3]) |=> warn_irq_o); // R9

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] == 1'b0); // R8
endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_lvr_en  (cfg_lvr_en),
    .lv_below_i  (lv_below_i),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sys_rst_n_o (sys_rst_n_o),
    .warn_irq_o  (warn_irq_o),
    .toggle      (warn_toggle)
);

// File: tb/supmon_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for supmon_rst_ctrl: a table-driven pass over the warning interrupt,
// then directed tests of the reset stretch and the corner cases.
module supmon_rst_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lvr_en = 1'b1;
    logic       cfg_long_dly = 1'b0;
    logic       lv_below_i = 1'b0;
    logic       warn_cmp_i = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst_n_o;
    logic       warn_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    supmon_rst_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_lvr_en   (cfg_lvr_en),
        .cfg_long_dly (cfg_long_dly),
        .lv_below_i   (lv_below_i),
        .warn_cmp_i   (warn_cmp_i),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sys_rst_n_o  (sys_rst_n_o),
        .warn_irq_o   (warn_irq_o)
    );

    // Step fields: {warn_in, ie, clr, write_bit0, exp_status, exp_pending}
    localparam logic [5:0] STEPS [0:8] = '{
        6'b0_1_0_0_0_0,   // enable, no change
        6'b1_1_0_0_1_1,   // supply falls: pending
        6'b1_1_1_0_1_0,   // clear
        6'b0_1_0_0_0_1,   // supply rises: pending
        6'b0_1_0_0_0_1,   // sticky
        6'b0_0_1_0_0_0,   // clear, disable
        6'b1_0_0_0_1_0,   // masked change
        6'b0_0_0_1_0_0,   // masked change, write to status ignored
        6'b0_1_0_0_0_0    // enabling later sets nothing
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        tick(1);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic chip_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    // Counts edges until the reset output is seen high
    task automatic wait_release(output int n);
        n = 0;
        while (n < 6000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (sys_rst_n_o) break;
        end
    endtask

    initial begin
        int n;
        tick(2);
        // Reset state
        check("R1 reset state rst", int'(sys_rst_n_o), 0);
        check("R8 reset state irq", int'(warn_irq_o), 0);
        check("R4 reset state reg", int'(reg_rdata), 0);
        rst_n = 1'b1;
        wait_release(n);
        check("R3 short stretch after chip reset", n, 256);

        // Table-driven warning interrupt sequence (R4, R6, R8)
        for (int i = 0; i < 9; i++) begin
            warn_cmp_i = STEPS[i][5];
            reg_write({4'b0, STEPS[i][3], 1'b0, STEPS[i][4], STEPS[i][2]});
            tick(4);
            check($sformatf("R4 step %0d status", i), int'(reg_rdata[0]), int'(STEPS[i][1]));
            check($sformatf("R6 step %0d pending", i), int'(warn_irq_o), int'(STEPS[i][0]));
            check($sformatf("R8 step %0d pend bit", i), int'(reg_rdata[2]), int'(STEPS[i][0]));
        end

        // R4: status valid exactly two edges after the input changes
        warn_cmp_i = 1'b1;
        tick(1);
        check("R4 status before sync", int'(reg_rdata[0]), 0);
        tick(1);
        check("R4 status after two edges", int'(reg_rdata[0]), 1);
        tick(2);
        check("R6 pending on fall", int'(warn_irq_o), 1);
        reg_write(8'h0A);

        // R9: clear lands on the same edge as the set
        warn_cmp_i = 1'b0;
        tick(2);
        reg_write(8'h0A);
        check("R9 set wins over clear", int'(warn_irq_o), 1);
        reg_write(8'h0A);
        check("R8 write-1 clears", int'(warn_irq_o), 0);

        // R1: low-voltage input drives reset low on the next edge
        lv_below_i = 1'b1;
        tick(1);
        check("R1 reset asserted", int'(sys_rst_n_o), 0);
        tick(5);
        lv_below_i = 1'b0;
        wait_release(n);
        check("R3 stretch after low-voltage", n, 256);

        // R10: reassert during stretch restarts the count
        lv_below_i = 1'b1;
        tick(1);
        lv_below_i = 1'b0;
        tick(100);
        lv_below_i = 1'b1;
        tick(1);
        lv_below_i = 1'b0;
        wait_release(n);
        check("R10 stretch restarts", n, 256);

        // R7: warning changes inside reset and stretch raise nothing
        warn_cmp_i = 1'b1;
        tick(4);
        check("R6 pending before dip", int'(warn_irq_o), 1);
        reg_write(8'h0A);
        lv_below_i = 1'b1;
        tick(10);
        lv_below_i = 1'b0;
        tick(30);
        warn_cmp_i = 1'b0;   // supply recovers within the stretch
        wait_release(n);
        tick(4);
        check("R7 no irq for recovery in stretch", int'(warn_irq_o), 0);
        check("R7 status after recovery", int'(reg_rdata[0]), 0);

        // R3: long stretch
        cfg_long_dly = 1'b1;
        chip_reset();
        wait_release(n);
        check("R3 long stretch", n, 4096);

        // R2 and R5: function disabled
        cfg_long_dly = 1'b0;
        cfg_lvr_en = 1'b0;
        chip_reset();
        wait_release(n);
        check("R3 stretch with option off", n, 256);
        reg_write(8'h02);
        lv_below_i = 1'b1;
        warn_cmp_i = 1'b1;
        tick(10);
        check("R2 lv ignored when off", int'(sys_rst_n_o), 1);
        check("R5 status zero when off", int'(reg_rdata[0]), 0);
        check("R5 no irq when off", int'(warn_irq_o), 0);
        lv_below_i = 1'b0;
        warn_cmp_i = 1'b0;
        tick(10);
        check("R5 no irq after change when off", int'(warn_irq_o), 0);

        done = 1;
    end

    // Watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule